// File: doc/BRIEF.md
# Linear-Model Read Address Generator

This block issues read addresses into a 128-word buffer that is otherwise read as a plain FIFO. Each incoming read strobe yields a new address together with an outgoing strobe one clock later. Normally the address steps by one word. A linear delay model can make it skip a word or repeat one. An accumulator is seeded with a delay-error value, and the delay rate is added to it on every strobe. Each time that addition overflows 32 bits, the step for that strobe becomes two words or zero words, as selected by a mode bit.

A reload event restarts the model. It returns the address to zero, seeds the accumulator from the error input, and captures new rate and mode values. The buffer itself, its write side and the logic that picks the reload event all sit outside this block.

Top module: `lin_delay_addr_gen`

## Requirements
- R1: After reset, `rdAddrOut` is 0 and `rdStrobeOut` is 0.
- R2: `rdStrobeOut` is 1 in the clock cycle after a cycle in which `rdStrobeIn` is 1, and 0 after a cycle in which it is 0. The matching address is on `rdAddrOut` in that same cycle.
- R3: On a strobe without reload, the latched rate is added to the 32-bit accumulator. If the sum does not exceed 32 bits, the address advances by 1.
- R4: On a strobe whose sum carries into bit 32, the address advances by 2 when the latched mode is 1.
- R5: On a strobe whose sum carries into bit 32, the address does not advance when the latched mode is 0.
- R6: After a carry, the accumulator keeps the low 32 bits of the sum, and later strobes continue from that remainder.
- R7: A reload sets the address to 0. It loads the accumulator with `delayErrIn` and latches `delayRateIn` and `stepModeIn`. A reload without a strobe leaves `rdStrobeOut` at 0 in the next cycle.
- R8: When a reload and a strobe share a cycle, the reload takes precedence. The next cycle shows `rdStrobeOut` = 1 with address 0, and the accumulator is not advanced by that strobe.
- R9: Changes on `delayErrIn`, `delayRateIn` and `stepModeIn` outside a reload cycle have no effect on later addresses.
- R10: The address wraps modulo 128 (for example, 127 + 1 gives 0 and 127 + 2 gives 1).
- R11: In a cycle with neither a strobe nor a reload, the address does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobeIn | input | 1 | Request for the next read address |
| reloadIn | input | 1 | Restart the delay model and return the address to 0 |
| delayErrIn | input | 32 | Accumulator seed, sampled on reload |
| delayRateIn | input | 18 | Per-strobe increment, sampled on reload |
| stepModeIn | input | 1 | Step on carry, sampled on reload: 1 gives a step of 2, 0 gives a step of 0 |
| rdAddrOut | output | 7 | Current buffer read address |
| rdStrobeOut | output | 1 | Strobe that accompanies a new address |

## Verification
The bench chooses seeds so that the very first strobe after a reload carries. A design that checked the carry against the old accumulator, or that kept the wrong bits, would then step by 1 where 2 or 0 is due. A long sweep uses a large seed and a large rate, so carries are separated by thousands of strobes. If the remainder were discarded or the seed reapplied after a carry, the carries would drift out of place against the arithmetic model. Other cases cover wrap at 127 in both modes, a reload that coincides with a strobe, and rate and mode changes without a reload. These catch a strobe that beats the reload, and inputs that leak into the model outside a reload.

// File: rtl/ldag_pkg.sv
package ldag_pkg;
  // Command from control to datapath for one clock.
  typedef struct packed {
    logic       load;     // restart model, address to zero
    logic       advance;  // accumulate and step address
    logic [1:0] inc;      // address step: 0, 1 or 2
  } ldag_cmd_t;
endpackage

// File: rtl/ldag_datapath.sv
module ldag_datapath
  import ldag_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int ACC_W  = 32,
  parameter int RATE_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldag_cmd_t         cmd,
  input  logic [ACC_W-1:0]  delayErr,
  input  logic [RATE_W-1:0] delayRate,
  input  logic              stepMode,
  output logic              carryNext,
  output logic              modeLatched,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int SUM_W = ACC_W + 1;
  localparam int PAD_W = SUM_W - RATE_W;

  logic [ACC_W-1:0]  accQ;
  logic [RATE_W-1:0] rateQ;
  logic              modeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [SUM_W-1:0]  sum;

  assign sum         = {1'b0, accQ} + {{PAD_W{1'b0}}, rateQ};
  assign carryNext   = sum[ACC_W];
  assign modeLatched = modeQ;
  assign addrOut     = addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      rateQ <= '0;
      modeQ <= 1'b0;
      addrQ <= '0;
    end else if (cmd.load) begin
      accQ  <= delayErr;
      rateQ <= delayRate;
      modeQ <= stepMode;
      addrQ <= '0;
    end else if (cmd.advance) begin
      accQ  <= sum[ACC_W-1:0];
      addrQ <= addrQ + ADDR_W'(cmd.inc);
    end
  end
endmodule

// File: rtl/ldag_ctrl.sv
module ldag_ctrl
  import ldag_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdStrobe,
  input  logic      reload,
  input  logic      carryNext,
  input  logic      modeLatched,
  output ldag_cmd_t cmd,
  output logic      strobeOut
);
  logic strobeQ;

  always_comb begin
    cmd.load    = reload;
    cmd.advance = rdStrobe && !reload;
    if (!carryNext)
      cmd.inc = 2'd1;
    else if (modeLatched)
      cmd.inc = 2'd2;
    else
      cmd.inc = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) strobeQ <= 1'b0;
    else       strobeQ <= rdStrobe;
  end

  assign strobeOut = strobeQ;
endmodule

// File: rtl/lin_delay_addr_gen.sv
module lin_delay_addr_gen
  import ldag_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int ACC_W  = 32,
  parameter int RATE_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobeIn,
  input  logic              reloadIn,
  input  logic [ACC_W-1:0]  delayErrIn,
  input  logic [RATE_W-1:0] delayRateIn,
  input  logic              stepModeIn,
  output logic [ADDR_W-1:0] rdAddrOut,
  output logic              rdStrobeOut
);
  ldag_cmd_t cmd;
  logic      carryNext;
  logic      modeLatched;

  ldag_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rdStrobe    (rdStrobeIn),
    .reload      (reloadIn),
    .carryNext   (carryNext),
    .modeLatched (modeLatched),
    .cmd         (cmd),
    .strobeOut   (rdStrobeOut)
  );

  ldag_datapath #(.ADDR_W(ADDR_W), .ACC_W(ACC_W), .RATE_W(RATE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .delayErr    (delayErrIn),
    .delayRate   (delayRateIn),
    .stepMode    (stepModeIn),
    .carryNext   (carryNext),
    .modeLatched (modeLatched),
    .addrOut     (rdAddrOut)
  );
endmodule

// File: rtl/ldag_checker.sv
module ldag_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStrobeIn,
  input logic              reloadIn,
  input logic              stepModeIn,
  input logic [ADDR_W-1:0] rdAddrOut,
  input logic              rdStrobeOut
);
  logic [ADDR_W-1:0] prevAddr;
  logic [ADDR_W-1:0] delta;
  logic              modeSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAddr <= '0;
      modeSeen <= 1'b0;
    end else begin
      prevAddr <= rdAddrOut;
      if (reloadIn) modeSeen <= stepModeIn;
    end
  end

  assign delta = rdAddrOut - prevAddr;

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobeIn |=> rdStrobeOut); // R2
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobeIn |=> !rdStrobeOut); // R2
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    reloadIn |=> (rdAddrOut == '0)); // R7
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (reloadIn && rdStrobeIn) |=> (rdStrobeOut && rdAddrOut == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobeIn && !reloadIn) |=> (delta == '0)); // R11
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobeIn && !reloadIn) |=> (delta <= ADDR_W'(2))); // R3
  AST_MODE0_NO_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobeIn && !reloadIn && !modeSeen) |=> (delta != ADDR_W'(2))); // R5
  AST_MODE1_NO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobeIn && !reloadIn && modeSeen) |=> (delta != '0)); // R4
endmodule

bind lin_delay_addr_gen ldag_checker #(.ADDR_W(ADDR_W)) u_ldag_checker (
  .clk         (clk),
  .rstN        (rstN),
  .rdStrobeIn  (rdStrobeIn),
  .reloadIn    (reloadIn),
  .stepModeIn  (stepModeIn),
  .rdAddrOut   (rdAddrOut),
  .rdStrobeOut (rdStrobeOut)
);

// File: tb/lin_delay_addr_gen_bench.sv
module lin_delay_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdStrobeIn = 1'b0;
  logic        reloadIn = 1'b0;
  logic [31:0] delayErrIn = '0;
  logic [17:0] delayRateIn = '0;
  logic        stepModeIn = 1'b0;
  logic [6:0]  rdAddrOut;
  logic        rdStrobeOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench-side model of the delay arithmetic
  logic [31:0] mAcc = '0;
  logic [17:0] mRate = '0;
  logic        mMode = 1'b0;
  int          mAddr = 0;
  int          carriesSeen = 0;

  always #4 clk = ~clk;

  lin_delay_addr_gen u_lin_delay_addr_gen (
    .clk(clk), .rstN(rstN), .rdStrobeIn(rdStrobeIn), .reloadIn(reloadIn),
    .delayErrIn(delayErrIn), .delayRateIn(delayRateIn), .stepModeIn(stepModeIn),
    .rdAddrOut(rdAddrOut), .rdStrobeOut(rdStrobeOut)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: inputs applied at negedge, outputs sampled next negedge.
  task automatic cycle(bit strb, bit rel, string req);
    logic [32:0] s;
    rdStrobeIn = strb;
    reloadIn   = rel;
    @(posedge clk);
    if (rel) begin
      mAcc = delayErrIn; mRate = delayRateIn; mMode = stepModeIn; mAddr = 0;
    end else if (strb) begin
      s = {1'b0, mAcc} + {15'd0, mRate};
      mAcc = s[31:0];
      if (s[32]) begin
        carriesSeen++;
        mAddr = (mAddr + (mMode ? 2 : 0)) % 128;
      end else begin
        mAddr = (mAddr + 1) % 128;
      end
    end
    @(negedge clk);
    rdStrobeIn = 1'b0;
    reloadIn   = 1'b0;
    check({req, " addr"}, int'(rdAddrOut), mAddr);
    check({req, " strobe"}, int'(rdStrobeOut), int'(strb));
  endtask

  task automatic reload(logic [31:0] e, logic [17:0] r, bit m, string req);
    delayErrIn = e; delayRateIn = r; stepModeIn = m;
    cycle(1'b0, 1'b1, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset addr", int'(rdAddrOut), 0);
    check("R1 reset strobe", int'(rdStrobeOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 R10: plain stepping across wrap
    reload(32'd0, 18'd1, 1'b0, "R7 reload");
    for (int i = 0; i < 200; i++) cycle(1'b1, 1'b0, "R3_R10 step1");

    // R4: carry on first strobe, mode 1, then wrap with step 2
    reload(32'hFFFF_FFF0, 18'd16, 1'b1, "R7 reload m1");
    cycle(1'b1, 1'b0, "R4 first carry");
    check("R4 addr is 2", int'(rdAddrOut), 2);
    reload(32'hFFFF_FF00, 18'd2, 1'b1, "R7 reload m1b");
    for (int i = 0; i < 300; i++) cycle(1'b1, 1'b0, "R4_R10 mode1 sweep");

    // R5: carry with mode 0 holds address
    reload(32'hFFFF_FFF0, 18'd16, 1'b0, "R7 reload m0");
    cycle(1'b1, 1'b0, "R5 first carry");
    check("R5 addr held at 0", int'(rdAddrOut), 0);
    for (int i = 0; i < 300; i++) cycle(1'b1, 1'b0, "R5 mode0 sweep");
    reload(32'h8000_0000, 18'h3FFFF, 1'b0, "R7 reload m0b");
    for (int i = 0; i < 300; i++) cycle(1'b1, 1'b0, "R5 mode0 dense");

    // R6: long sweep, remainder carried across rare carries
    carriesSeen = 0;
    reload(32'hFFFE_0000, 18'h3FFFF, 1'b1, "R7 reload long");
    for (int i = 0; i < 40000; i++) cycle(1'b1, 1'b0, "R6 remainder sweep");
    check("R6 carry count", carriesSeen, 3);

    // R9: input changes outside reload ignored
    reload(32'h1234_5678, 18'h00ABC, 1'b1, "R7 reload R9");
    for (int i = 0; i < 50; i++) begin
      delayErrIn  = 32'hFFFF_FFFF - i;
      delayRateIn = 18'h3FFFF;
      stepModeIn  = i[0];
      cycle(1'b1, 1'b0, "R9 ignored inputs");
    end

    // R11: idle gaps hold address and strobe low
    for (int i = 0; i < 40; i++) begin
      cycle(1'b1, 1'b0, "R11 strobe");
      cycle(1'b0, 1'b0, "R11 idle hold");
      cycle(1'b0, 1'b0, "R11 idle hold2");
    end

    // R7: reload without strobe mid-stream
    delayErrIn = 32'hFFFF_FFFF; delayRateIn = 18'd1; stepModeIn = 1'b0;
    cycle(1'b0, 1'b1, "R7 reload no strobe");
    check("R7 addr zero", int'(rdAddrOut), 0);
    cycle(1'b1, 1'b0, "R7 seeded carry m0");
    check("R7 seed used", int'(rdAddrOut), 0);

    // R8: reload and strobe together
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, "R8 pre");
    delayErrIn = 32'hFFFF_FFFE; delayRateIn = 18'd2; stepModeIn = 1'b1;
    cycle(1'b1, 1'b1, "R8 reload wins");
    check("R8 addr zero", int'(rdAddrOut), 0);
    check("R8 strobe out", int'(rdStrobeOut), 1);
    cycle(1'b1, 1'b0, "R8 acc not advanced");
    check("R8 carry on next strobe", int'(rdAddrOut), 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule